// File: doc/BRIEF.md
# Asynchronous NOR Flash Bus Controller

The controller runs one access at a time against an asynchronous NOR flash: a single-word read, a page read of up to four words, or a single-word write. Each access is laid out on a cycle counter that starts at zero in the first functional-clock cycle after the request is accepted. Every strobe edge is a configured count. When the granularity bit is set, each count is doubled. Chip select, address valid, output enable and write enable can each be moved half a clock cycle later, and that shift applies to both edges of the strobe.

Requests use a valid/ready handshake. A request is taken on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` then stays low for the whole access and for the idle gap that follows it. The requester must hold the request steady until it is accepted. Read data comes back as a one-cycle `rsp_valid` pulse with no back-pressure, so the consumer must take every word in the cycle it is presented. The address can go out on a dedicated bus, or in multiplexed mode on the shared data lines ahead of the data. Configuration inputs must stay constant while `req_ready` is low.

In this brief, s is 2 when `cfg_gran` is 1 and 1 otherwise. Cycle c is the c-th clock cycle after the accepting edge, counting from 0. n is the number of words in the access, and X·s means a configured count scaled by s.

Top module: `nor_async_ctrl`

## Requirements
- R1: `req_ready` is high only while the controller is idle. After an accepting edge it stays low from cycle 0 through the end of the access and the gap. Requests presented while it is low are not taken.
- R2: Only the line of `cs_n` selected by `req_cs` goes low, for cycles cs_on·s up to, but not including, the off count. The off count is `cfg_cs_wr_off`·s for writes and `cfg_cs_rd_off`·s+(n−1)·page·s for reads. All other lines stay high.
- R3: With `cfg_gran`=1, every configured count is doubled. This covers strobe edges, sample points, cycle lengths and the gap.
- R4: `cfg_half` bit 0 shifts chip select, bit 1 address valid, bit 2 output enable and bit 3 write enable. A set bit moves both edges of that strobe half a clock cycle later, so the strobe changes on the falling clock edge.
- R5: On reads, `oe_n` is low from oe_on·s until oe_off·s+(n−1)·page·s and `we_n` stays high. On writes, `we_n` is low from we_on·s until we_off·s and `oe_n` stays high.
- R6: `adv_n` is low from adv_on·s until `cfg_adv_rd_off`·s on reads, or until `cfg_adv_wr_off`·s on writes.
- R7: A single read samples `ad_i` at the rising edge that closes cycle acc·s−1. `rsp_valid` is high in cycle acc·s with that data.
- R8: A page read transfers n = `req_len`+1 words. Word k is sampled at the end of cycle (acc+k·page)·s−1 while `addr_o` = base+k, and `addr_o` steps to the next word right after each sample. The read lasts (rd_cyc+(n−1)·page)·s cycles.
- R9: A write is always a single word, whatever `req_len` holds, and lasts wr_cyc·s cycles. `ben_n` is the inverse of `req_ben` for the whole access. With the address on its own bus, `ad_oe` is high and `ad_o` carries the write data from we_on·s to the end of the access.
- R10: In multiplexed mode, `ad_oe` is high and `ad_o` carries the low address bits from cycle 0 until oe_on·s on reads, or until we_on·s on writes, after which a write drives its data. On reads with a separate address bus, `ad_oe` never rises.
- R11: Outside an access, including the gap of gap·s cycles, `addr_o` is 0 and `ben_n` is all ones.
- R12: `rsp_valid` is high only in the cycle that follows a sample. No pulse occurs on writes or outside reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address of first word |
| req_wdata | input | DW | Write data |
| req_ben | input | DW/8 | Active-high byte enables |
| req_cs | input | $clog2(NCS) | Chip-select index |
| req_len | input | LW | Page word count minus one (reads) |
| cfg_gran | input | 1 | Granularity: 1 doubles every count |
| cfg_mux | input | 1 | 1 = address on the data lines |
| cfg_half | input | 4 | Half-cycle shift for cs, adv, oe, we |
| cfg_cs_on | input | TW | Chip select assert count |
| cfg_cs_rd_off | input | TW | Chip select release count, reads |
| cfg_cs_wr_off | input | TW | Chip select release count, writes |
| cfg_adv_on | input | TW | Address valid assert count |
| cfg_adv_rd_off | input | TW | Address valid release count, reads |
| cfg_adv_wr_off | input | TW | Address valid release count, writes |
| cfg_oe_on | input | TW | Output enable assert count |
| cfg_oe_off | input | TW | Output enable release count |
| cfg_we_on | input | TW | Write enable assert count |
| cfg_we_off | input | TW | Write enable release count |
| cfg_acc | input | TW | First-word access time |
| cfg_page | input | TW | Page word interval |
| cfg_rd_cyc | input | TW | Read cycle length |
| cfg_wr_cyc | input | TW | Write cycle length |
| cfg_gap | input | TW | Idle gap between accesses |
| rsp_valid | output | 1 | Read word pulse |
| rsp_data | output | DW | Read word |
| cs_n | output | NCS | Active-low chip selects |
| adv_n | output | 1 | Active-low address valid |
| oe_n | output | 1 | Active-low output enable |
| we_n | output | 1 | Active-low write enable |
| ben_n | output | DW/8 | Active-low byte enables |
| addr_o | output | AW | Address bus |
| ad_o | output | DW | Data/address lines, driven value |
| ad_i | input | DW | Data lines, received value |
| ad_oe | output | 1 | Data-line drive direction |

## Verification
A counter that is off by one moves a strobe edge, a sample point and the end of the access together. The bench compares every strobe against the computed window in both halves of every cycle, so such an error appears at the first edge it affects, within one clock. A stale word index shows up on `addr_o` in the cycle after a page sample, and also as wrong `rsp_data`. A wrong phase shows up as `req_ready` rising early or late, or as a nonzero address or byte enable in the gap.

// File: rtl/nor_pkg.sv
package nor_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_ACC, PH_GAP} phase_e;
  localparam int NSTRB  = 4;
  localparam int SI_CS  = 0;
  localparam int SI_ADV = 1;
  localparam int SI_OE  = 2;
  localparam int SI_WE  = 3;
endpackage

// File: rtl/nor_timebase.sv
module nor_timebase import nor_pkg::*; #(
  parameter int CW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] cyc_len,
  input  logic [CW-1:0] gap_len,
  output phase_e        phase,
  output logic [CW-1:0] t,
  output logic [CW-1:0] t_nxt,
  output logic          acc_nxt,
  output logic          ready
);
  phase_e phase_nxt;

  always_comb begin
    phase_nxt = phase;
    t_nxt     = t;
    unique case (phase)
      PH_IDLE: begin
        t_nxt = '0;
        if (start) phase_nxt = PH_ACC;
      end
      PH_ACC: begin
        if (t == cyc_len - CW'(1)) begin
          t_nxt     = '0;
          phase_nxt = (gap_len == '0) ? PH_IDLE : PH_GAP;
        end else begin
          t_nxt = t + CW'(1);
        end
      end
      PH_GAP: begin
        if (t == gap_len - CW'(1)) begin
          t_nxt     = '0;
          phase_nxt = PH_IDLE;
        end else begin
          t_nxt = t + CW'(1);
        end
      end
      default: begin
        t_nxt     = '0;
        phase_nxt = PH_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      t     <= '0;
    end else begin
      phase <= phase_nxt;
      t     <= t_nxt;
    end
  end

  assign acc_nxt = (phase_nxt == PH_ACC);
  assign ready   = (phase == PH_IDLE);
endmodule

// File: rtl/nor_strobe_gen.sv
module nor_strobe_gen import nor_pkg::*; #(
  parameter int TW = 5,
  parameter int LW = 2,
  parameter int CW = 9
) (
  input  logic             gran,
  input  logic             wr,
  input  logic [LW-1:0]    n1,
  input  logic             acc_nxt,
  input  logic [CW-1:0]    t_nxt,
  input  logic [TW-1:0]    cs_on,
  input  logic [TW-1:0]    cs_rd_off,
  input  logic [TW-1:0]    cs_wr_off,
  input  logic [TW-1:0]    adv_on,
  input  logic [TW-1:0]    adv_rd_off,
  input  logic [TW-1:0]    adv_wr_off,
  input  logic [TW-1:0]    oe_on,
  input  logic [TW-1:0]    oe_off,
  input  logic [TW-1:0]    we_on,
  input  logic [TW-1:0]    we_off,
  input  logic [TW-1:0]    acc,
  input  logic [TW-1:0]    page,
  input  logic [TW-1:0]    rd_cyc,
  input  logic [TW-1:0]    wr_cyc,
  input  logic [TW-1:0]    gap,
  output logic [NSTRB-1:0] act_nxt,
  output logic [CW-1:0]    cyc_len,
  output logic [CW-1:0]    gap_len,
  output logic [CW-1:0]    sc_acc,
  output logic [CW-1:0]    sc_page,
  output logic [CW-1:0]    sc_oe_on,
  output logic [CW-1:0]    sc_we_on
);
  function automatic logic [CW-1:0] scl(input logic g, input logic [TW-1:0] v);
    logic [CW-1:0] z;
    z = CW'(v);
    return g ? (z << 1) : z;
  endfunction

  logic [CW-1:0] ext;
  logic [CW-1:0] on_v  [NSTRB];
  logic [CW-1:0] off_v [NSTRB];
  logic [NSTRB-1:0] gate;

  always_comb begin
    sc_acc   = scl(gran, acc);
    sc_page  = scl(gran, page);
    sc_oe_on = scl(gran, oe_on);
    sc_we_on = scl(gran, we_on);
    ext      = CW'(n1) * sc_page;
    cyc_len  = wr ? scl(gran, wr_cyc) : scl(gran, rd_cyc) + ext;
    gap_len  = scl(gran, gap);

    on_v[SI_CS]   = scl(gran, cs_on);
    off_v[SI_CS]  = wr ? scl(gran, cs_wr_off) : scl(gran, cs_rd_off) + ext;
    gate[SI_CS]   = 1'b1;
    on_v[SI_ADV]  = scl(gran, adv_on);
    off_v[SI_ADV] = wr ? scl(gran, adv_wr_off) : scl(gran, adv_rd_off);
    gate[SI_ADV]  = 1'b1;
    on_v[SI_OE]   = sc_oe_on;
    off_v[SI_OE]  = scl(gran, oe_off) + ext;
    gate[SI_OE]   = !wr;
    on_v[SI_WE]   = sc_we_on;
    off_v[SI_WE]  = scl(gran, we_off);
    gate[SI_WE]   = wr;
  end

  for (genvar i = 0; i < NSTRB; i++) begin : g_win
    assign act_nxt[i] = acc_nxt && gate[i] &&
                        (t_nxt >= on_v[i]) && (t_nxt < off_v[i]);
  end
endmodule

// File: rtl/nor_edge_shift.sv
module nor_edge_shift (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  input  logic half,
  output logic q
);
  logic rise_q;
  logic fall_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rise_q <= 1'b0;
    else        rise_q <= d;
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) fall_q <= 1'b0;
    else        fall_q <= rise_q;
  end

  assign q = half ? fall_q : rise_q;
endmodule

// File: rtl/nor_datapath.sv
module nor_datapath import nor_pkg::*; #(
  parameter int AW  = 24,
  parameter int DW  = 16,
  parameter int LW  = 2,
  parameter int CW  = 9,
  parameter int CSW = 3,
  localparam int BW = DW / 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           req_write,
  input  logic [AW-1:0]  req_addr,
  input  logic [DW-1:0]  req_wdata,
  input  logic [BW-1:0]  req_ben,
  input  logic [CSW-1:0] req_cs,
  input  logic [LW-1:0]  req_len,
  input  logic           mux,
  input  phase_e         phase,
  input  logic [CW-1:0]  t,
  input  logic [CW-1:0]  sc_acc,
  input  logic [CW-1:0]  sc_page,
  input  logic [CW-1:0]  sc_oe_on,
  input  logic [CW-1:0]  sc_we_on,
  input  logic [DW-1:0]  ad_i,
  output logic           wr_eff,
  output logic [LW-1:0]  n1_eff,
  output logic [CSW-1:0] cs_idx,
  output logic [AW-1:0]  addr_o,
  output logic [BW-1:0]  ben_n,
  output logic [DW-1:0]  ad_o,
  output logic           ad_oe,
  output logic           rsp_valid,
  output logic [DW-1:0]  rsp_data
);
  logic          wr_q;
  logic [LW-1:0] n1_q;
  logic [LW-1:0] idx;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic [BW-1:0] ben_q;
  logic [LW-1:0] n1_req;
  logic [CW-1:0] target;
  logic          in_acc;
  logic          hit;

  assign n1_req = req_write ? '0 : req_len;
  assign wr_eff = start ? req_write : wr_q;
  assign n1_eff = start ? n1_req : n1_q;
  assign in_acc = (phase == PH_ACC);
  assign target = sc_acc + CW'(idx) * sc_page - CW'(1);
  assign hit    = in_acc && !wr_q && (t == target);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q      <= 1'b0;
      n1_q      <= '0;
      idx       <= '0;
      addr_q    <= '0;
      wdata_q   <= '0;
      ben_q     <= '0;
      cs_idx    <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (start) begin
        wr_q    <= req_write;
        n1_q    <= n1_req;
        idx     <= '0;
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
        ben_q   <= req_ben;
        cs_idx  <= req_cs;
      end else if (hit) begin
        rsp_valid <= 1'b1;
        rsp_data  <= ad_i;
        if (idx < n1_q) idx <= idx + LW'(1);
      end
    end
  end

  assign addr_o = in_acc ? addr_q + AW'(idx) : '0;
  assign ben_n  = in_acc ? ~ben_q : '1;

  always_comb begin
    ad_oe = 1'b0;
    ad_o  = '0;
    if (in_acc) begin
      if (mux) begin
        if (wr_q) begin
          ad_oe = 1'b1;
          ad_o  = (t < sc_we_on) ? addr_o[DW-1:0] : wdata_q;
        end else if (t < sc_oe_on) begin
          ad_oe = 1'b1;
          ad_o  = addr_o[DW-1:0];
        end
      end else if (wr_q && (t >= sc_we_on)) begin
        ad_oe = 1'b1;
        ad_o  = wdata_q;
      end
    end
  end
endmodule

// File: rtl/nor_async_ctrl.sv
module nor_async_ctrl import nor_pkg::*; #(
  parameter int AW  = 24,
  parameter int DW  = 16,
  parameter int TW  = 5,
  parameter int LW  = 2,
  parameter int NCS = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_write,
  input  logic [AW-1:0]          req_addr,
  input  logic [DW-1:0]          req_wdata,
  input  logic [DW/8-1:0]        req_ben,
  input  logic [$clog2(NCS)-1:0] req_cs,
  input  logic [LW-1:0]          req_len,
  input  logic                   cfg_gran,
  input  logic                   cfg_mux,
  input  logic [3:0]             cfg_half,
  input  logic [TW-1:0]          cfg_cs_on,
  input  logic [TW-1:0]          cfg_cs_rd_off,
  input  logic [TW-1:0]          cfg_cs_wr_off,
  input  logic [TW-1:0]          cfg_adv_on,
  input  logic [TW-1:0]          cfg_adv_rd_off,
  input  logic [TW-1:0]          cfg_adv_wr_off,
  input  logic [TW-1:0]          cfg_oe_on,
  input  logic [TW-1:0]          cfg_oe_off,
  input  logic [TW-1:0]          cfg_we_on,
  input  logic [TW-1:0]          cfg_we_off,
  input  logic [TW-1:0]          cfg_acc,
  input  logic [TW-1:0]          cfg_page,
  input  logic [TW-1:0]          cfg_rd_cyc,
  input  logic [TW-1:0]          cfg_wr_cyc,
  input  logic [TW-1:0]          cfg_gap,
  output logic                   rsp_valid,
  output logic [DW-1:0]          rsp_data,
  output logic [NCS-1:0]         cs_n,
  output logic                   adv_n,
  output logic                   oe_n,
  output logic                   we_n,
  output logic [DW/8-1:0]        ben_n,
  output logic [AW-1:0]          addr_o,
  output logic [DW-1:0]          ad_o,
  input  logic [DW-1:0]          ad_i,
  output logic                   ad_oe
);
  localparam int CW  = TW + LW + 2;
  localparam int CSW = $clog2(NCS);

  phase_e           phase;
  logic [CW-1:0]    t;
  logic [CW-1:0]    t_nxt;
  logic             acc_nxt;
  logic             start;
  logic             wr_eff;
  logic [LW-1:0]    n1_eff;
  logic [CSW-1:0]   cs_idx;
  logic [NSTRB-1:0] act_nxt;
  logic [NSTRB-1:0] strb;
  logic [CW-1:0]    cyc_len;
  logic [CW-1:0]    gap_len;
  logic [CW-1:0]    sc_acc;
  logic [CW-1:0]    sc_page;
  logic [CW-1:0]    sc_oe_on;
  logic [CW-1:0]    sc_we_on;

  assign start = req_valid && req_ready;

  nor_timebase #(.CW(CW)) u_tb (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .cyc_len (cyc_len),
    .gap_len (gap_len),
    .phase   (phase),
    .t       (t),
    .t_nxt   (t_nxt),
    .acc_nxt (acc_nxt),
    .ready   (req_ready)
  );

  nor_strobe_gen #(.TW(TW), .LW(LW), .CW(CW)) u_sg (
    .gran       (cfg_gran),
    .wr         (wr_eff),
    .n1         (n1_eff),
    .acc_nxt    (acc_nxt),
    .t_nxt      (t_nxt),
    .cs_on      (cfg_cs_on),
    .cs_rd_off  (cfg_cs_rd_off),
    .cs_wr_off  (cfg_cs_wr_off),
    .adv_on     (cfg_adv_on),
    .adv_rd_off (cfg_adv_rd_off),
    .adv_wr_off (cfg_adv_wr_off),
    .oe_on      (cfg_oe_on),
    .oe_off     (cfg_oe_off),
    .we_on      (cfg_we_on),
    .we_off     (cfg_we_off),
    .acc        (cfg_acc),
    .page       (cfg_page),
    .rd_cyc     (cfg_rd_cyc),
    .wr_cyc     (cfg_wr_cyc),
    .gap        (cfg_gap),
    .act_nxt    (act_nxt),
    .cyc_len    (cyc_len),
    .gap_len    (gap_len),
    .sc_acc     (sc_acc),
    .sc_page    (sc_page),
    .sc_oe_on   (sc_oe_on),
    .sc_we_on   (sc_we_on)
  );

  for (genvar i = 0; i < NSTRB; i++) begin : g_shift
    nor_edge_shift u_sh (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (act_nxt[i]),
      .half  (cfg_half[i]),
      .q     (strb[i])
    );
  end

  nor_datapath #(.AW(AW), .DW(DW), .LW(LW), .CW(CW), .CSW(CSW)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .req_ben   (req_ben),
    .req_cs    (req_cs),
    .req_len   (req_len),
    .mux       (cfg_mux),
    .phase     (phase),
    .t         (t),
    .sc_acc    (sc_acc),
    .sc_page   (sc_page),
    .sc_oe_on  (sc_oe_on),
    .sc_we_on  (sc_we_on),
    .ad_i      (ad_i),
    .wr_eff    (wr_eff),
    .n1_eff    (n1_eff),
    .cs_idx    (cs_idx),
    .addr_o    (addr_o),
    .ben_n     (ben_n),
    .ad_o      (ad_o),
    .ad_oe     (ad_oe),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data)
  );

  for (genvar j = 0; j < NCS; j++) begin : g_cs
    assign cs_n[j] = !(strb[SI_CS] && (cs_idx == CSW'(j)));
  end

  assign adv_n = !strb[SI_ADV];
  assign oe_n  = !strb[SI_OE];
  assign we_n  = !strb[SI_WE];
endmodule

// File: rtl/nor_async_ctrl_chk.sv
module nor_async_ctrl_chk #(
  parameter int NCS = 8,
  parameter int AW  = 24,
  parameter int BW  = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           req_valid,
  input logic           req_ready,
  input logic [NCS-1:0] cs_n,
  input logic           oe_n,
  input logic           we_n,
  input logic [BW-1:0]  ben_n,
  input logic [AW-1:0]  addr_o,
  input logic           ad_oe,
  input logic           rsp_valid
);
  // R1: an accepted request blocks the next one
  a_r1_accept_drops_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R2: never more than one chip select low
  a_r2_single_cs: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~cs_n) <= 1);

  // R5: read and write strobes never overlap
  a_r5_oe_we_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(!oe_n && !we_n));

  // R10: the controller never drives while the flash output is enabled
  a_r10_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
    !(ad_oe && !oe_n));

  // R11: idle bus carries no address and no byte enables
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (addr_o == '0 && ben_n == '1));

  // R12: a response follows a cycle in which the controller was busy
  a_r12_rsp_in_access: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(!req_ready));
endmodule

bind nor_async_ctrl nor_async_ctrl_chk #(.NCS(NCS), .AW(AW), .BW(DW/8)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .cs_n      (cs_n),
  .oe_n      (oe_n),
  .we_n      (we_n),
  .ben_n     (ben_n),
  .addr_o    (addr_o),
  .ad_oe     (ad_oe),
  .rsp_valid (rsp_valid)
);

// File: tb/sim_nor_async_ctrl.sv
`timescale 1ns/1ps
module sim_nor_async_ctrl;
  localparam int AW = 24, DW = 16, TW = 5, LW = 2, NCS = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n;
  logic req_valid, req_ready, req_write;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic [1:0] req_ben;
  logic [2:0] req_cs;
  logic [LW-1:0] req_len;
  logic cfg_gran, cfg_mux;
  logic [3:0] cfg_half;
  logic rsp_valid;
  logic [DW-1:0] rsp_data;
  logic [NCS-1:0] cs_n;
  logic adv_n, oe_n, we_n, ad_oe;
  logic [1:0] ben_n;
  logic [AW-1:0] addr_o;
  logic [DW-1:0] ad_o, ad_i;

  int k_cs_on, k_cs_rd_off, k_cs_wr_off, k_adv_on, k_adv_rd_off, k_adv_wr_off;
  int k_oe_on, k_oe_off, k_we_on, k_we_off, k_acc, k_page, k_rd, k_wr, k_gap;

  // flash model: read data is a fixed function of the address
  assign ad_i = addr_o[DW-1:0] ^ 16'h5A3C;

  nor_async_ctrl #(.AW(AW), .DW(DW), .TW(TW), .LW(LW), .NCS(NCS)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_ben(req_ben), .req_cs(req_cs), .req_len(req_len),
    .cfg_gran(cfg_gran), .cfg_mux(cfg_mux), .cfg_half(cfg_half),
    .cfg_cs_on(TW'(k_cs_on)), .cfg_cs_rd_off(TW'(k_cs_rd_off)),
    .cfg_cs_wr_off(TW'(k_cs_wr_off)), .cfg_adv_on(TW'(k_adv_on)),
    .cfg_adv_rd_off(TW'(k_adv_rd_off)), .cfg_adv_wr_off(TW'(k_adv_wr_off)),
    .cfg_oe_on(TW'(k_oe_on)), .cfg_oe_off(TW'(k_oe_off)),
    .cfg_we_on(TW'(k_we_on)), .cfg_we_off(TW'(k_we_off)),
    .cfg_acc(TW'(k_acc)), .cfg_page(TW'(k_page)), .cfg_rd_cyc(TW'(k_rd)),
    .cfg_wr_cyc(TW'(k_wr)), .cfg_gap(TW'(k_gap)),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .cs_n(cs_n), .adv_n(adv_n),
    .oe_n(oe_n), .we_n(we_n), .ben_n(ben_n), .addr_o(addr_o), .ad_o(ad_o),
    .ad_i(ad_i), .ad_oe(ad_oe)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  int s, n1, ext, cyc, gp, cur_w, cur_base, cur_cs;
  logic [DW-1:0] cur_wd;
  logic [1:0] cur_ben;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s t=%0t actual=%0h expected=%0h", tag, $time, act, exp);
    end
  endtask

  function automatic bit win(int c, int on, int off);
    return (c >= on) && (c < off);
  endfunction

  function automatic bit cond(int k, int c);
    if (c < 0 || c >= cyc) return 1'b0;
    case (k)
      0: return win(c, k_cs_on*s, cur_w ? k_cs_wr_off*s : k_cs_rd_off*s + ext);
      1: return win(c, k_adv_on*s, cur_w ? k_adv_wr_off*s : k_adv_rd_off*s);
      2: return !cur_w && win(c, k_oe_on*s, k_oe_off*s + ext);
      default: return cur_w && win(c, k_we_on*s, k_we_off*s);
    endcase
  endfunction

  function automatic string stag(int k);
    if (cfg_half[k]) return "R4";
    if (cfg_gran) return "R3";
    if (k == 0) return "R2";
    if (k == 1) return "R6";
    return "R5";
  endfunction

  function automatic int done_cnt(int c);
    int cnt = 0;
    for (int k = 0; k <= n1; k++)
      if ((k_acc + k*k_page)*s <= c) cnt++;
    return (cnt > n1) ? n1 : cnt;
  endfunction

  function automatic int rsp_k(int c);
    if (cur_w) return -1;
    for (int k = 0; k <= n1; k++)
      if ((k_acc + k*k_page)*s == c) return k;
    return -1;
  endfunction

  task automatic check_half(int c, bit second);
    for (int k = 0; k < 4; k++) begin
      bit d;
      if (second) d = cond(k, c);
      else d = cfg_half[k] ? cond(k, c-1) : cond(k, c);
      case (k)
        0: begin
          logic [NCS-1:0] e;
          e = '1;
          if (d) e[cur_cs] = 1'b0;
          chk(cs_n == e, stag(k), cs_n, e);
        end
        1: chk(adv_n == !d, stag(k), adv_n, !d);
        2: chk(oe_n == !d, stag(k), oe_n, !d);
        default: chk(we_n == !d, stag(k), we_n, !d);
      endcase
    end
    if (!second) begin
      bit in_acc, eo;
      logic [AW-1:0] ea;
      logic [1:0] eb;
      logic [DW-1:0] ed;
      int rk;
      in_acc = (c < cyc);
      ea = in_acc ? AW'(cur_base + done_cnt(c)) : '0;
      eb = in_acc ? ~cur_ben : 2'b11;
      chk(addr_o == ea, in_acc ? (cur_w ? "R9" : "R8") : "R11", addr_o, ea);
      chk(ben_n == eb, in_acc ? "R9" : "R11", ben_n, eb);
      eo = 1'b0;
      ed = '0;
      if (in_acc) begin
        if (cfg_mux) begin
          if (cur_w) begin
            eo = 1'b1;
            ed = (c < k_we_on*s) ? DW'(cur_base) : cur_wd;
          end else if (c < k_oe_on*s) begin
            eo = 1'b1;
            ed = DW'(cur_base);
          end
        end else if (cur_w && c >= k_we_on*s) begin
          eo = 1'b1;
          ed = cur_wd;
        end
      end
      chk(ad_oe == eo, cfg_mux ? "R10" : "R9", ad_oe, eo);
      if (eo) chk(ad_o == ed, cfg_mux ? "R10" : "R9", ad_o, ed);
      rk = rsp_k(c);
      chk(rsp_valid == (rk >= 0), (rk >= 0) ? (n1 > 0 ? "R8" : "R7") : "R12",
          rsp_valid, (rk >= 0));
      if (rk >= 0) begin
        logic [DW-1:0] ev;
        ev = DW'(cur_base + rk) ^ 16'h5A3C;
        chk(rsp_data == ev, n1 > 0 ? "R8" : "R7", rsp_data, ev);
      end
      chk(req_ready == (c == cyc + gp), "R1", req_ready, (c == cyc + gp));
    end
  endtask

  // enters and leaves in the second half of an idle cycle
  task automatic run_one(bit w, int len_f, int base, int cs, bit hold);
    s = cfg_gran ? 2 : 1;
    n1 = w ? 0 : len_f;
    ext = n1 * k_page * s;
    cyc = w ? k_wr*s : (k_rd + n1*k_page)*s;
    gp = k_gap * s;
    cur_w = w; cur_base = base & 24'hFFFFFF; cur_cs = cs;
    cur_wd = DW'(16'hC000 ^ base);
    cur_ben = 2'(base + 1);
    if (cur_ben == 2'b00) cur_ben = 2'b10;
    req_valid = 1'b1; req_write = w; req_addr = AW'(base); req_len = LW'(len_f);
    req_cs = 3'(cs); req_wdata = cur_wd; req_ben = cur_ben;
    @(posedge clk);
    for (int c = 0; c <= cyc + gp; c++) begin
      #1;
      check_half(c, 1'b0);
      if (!hold || c == cyc + gp) req_valid = 1'b0;
      else req_addr = AW'(base ^ 24'h5555);  // R1: ignored while busy
      @(negedge clk);
      #1;
      check_half(c, 1'b1);
      if (c < cyc + gp) @(posedge clk);
    end
  endtask

  task automatic set_cfg(int set);
    if (set == 0) begin
      k_cs_on = 1; k_cs_rd_off = 7; k_cs_wr_off = 6; k_adv_on = 1; k_adv_rd_off = 3;
      k_adv_wr_off = 3; k_oe_on = 3; k_oe_off = 7; k_we_on = 2; k_we_off = 5;
      k_acc = 5; k_page = 2; k_rd = 8; k_wr = 7; k_gap = 2;
    end else begin
      k_cs_on = 0; k_cs_rd_off = 8; k_cs_wr_off = 4; k_adv_on = 0; k_adv_rd_off = 2;
      k_adv_wr_off = 1; k_oe_on = 1; k_oe_off = 8; k_we_on = 1; k_we_off = 4;
      k_acc = 8; k_page = 1; k_rd = 8; k_wr = 4; k_gap = 0;
    end
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int it;
    it = 0;
    set_cfg(0);
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0;
    req_wdata = '0; req_ben = '0; req_cs = '0; req_len = '0;
    cfg_gran = 1'b0; cfg_mux = 1'b0; cfg_half = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(req_ready == 1'b1, "R1", req_ready, 1);
    chk(cs_n == '1, "R2", cs_n, 8'hFF);
    chk(oe_n && we_n && adv_n, "R5", {oe_n, we_n, adv_n}, 3'b111);
    chk(ad_oe == 1'b0, "R10", ad_oe, 0);
    chk(rsp_valid == 1'b0, "R12", rsp_valid, 0);
    chk(addr_o == '0 && ben_n == 2'b11, "R11", {addr_o, ben_n}, 2'b11);
    for (int set = 0; set < 2; set++) begin
      set_cfg(set);
      for (int g = 0; g < 2; g++) begin
        for (int m = 0; m < 2; m++) begin
          for (int dl = 0; dl < 16; dl++) begin
            for (int op = 0; op < 6; op++) begin
              int base;
              cfg_gran = g[0]; cfg_mux = m[0]; cfg_half = 4'(dl);
              base = (it * 945 + 16) & 24'hFFFFFF;
              if (op == 3 && dl == 5) base = 24'h00FFFE;
              run_one(op >= 4, (op >= 4) ? ((op == 5) ? 3 : 0) : op, base,
                      it % NCS, ((op + dl) % 5) == 0);
              it++;
            end
          end
        end
      end
    end
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule